// File: doc/BRIEF.md
# Oversampled Full-Duplex Serial Transceiver

This block is an asynchronous serial transmitter and receiver pair that share one bit-rate generator. An 8-bit divisor sets a sub-bit tick that runs at sixteen times the line rate. Frames carry one low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one high stop bit.

On the host side there is a single data location. A write loads the transmit holding register. A read returns a physically separate receive holding register. Five status outputs report the state of the block: holding register empty, transmission finished, character received, bad stop bit, and a character lost because the previous one was not read.

The receiver samples its line on every sub-bit tick. One low sample on an idle line begins start-bit qualification. Each bit is decided by a two-of-three vote over the middle samples of the bit.

Top module: `uart_x16`

## Requirements
- R1: Every transmitted bit, including the start bit, lasts exactly 16*(div+1) clock cycles, for any `div` from 0 to 255.
- R2: A transmitted frame is a 0 start bit, then `wr_data` least significant bit first, then `wr_bit8` when `nine_bit` is 1, then a 1 stop bit. Between frames `txd` is 1.
- R3: `tx_empty` reads 0 in the cycle after a write. It returns to 1 at the same clock edge where the held byte moves into the shift register and the start bit appears on `txd`.
- R4: `tx_done` becomes 1 after the stop bit has been sent, but only if no byte is waiting in the holding register. A write clears it. While a second byte is queued back to back, `tx_done` stays 0 between the two frames.
- R5: The receiver decides each bit from samples 8, 9 and 10 of that bit, counting the first low sample as sample 1. When the stop bit is decided, `rd_data` holds the data bits and `rx_done` becomes 1. `rd_bit8` gives the ninth bit when `nine_bit` is 1 and is 0 otherwise.
- R6: A low pulse that gives a 1 vote for the start bit ends reception and returns the receiver to idle. No character is reported, and a frame that follows is received normally.
- R7: `frame_err` is 1 when the stop bit of the character in the receive holding register was decided as 0, and 0 when it was decided as 1.
- R8: When a character finishes while `rx_done` is still 1 and no read is in progress, `overrun` becomes 1 and the held character stays in place. The next character that is accepted clears `overrun`.
- R9: A read strobe `rd_en` clears `rx_done`.
- R10: After reset, `txd`, `tx_empty` are 1 and `tx_done`, `rx_done`, `frame_err`, `overrun` are 0.
- R11: A write to the transmit holding register leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div | input | 8 | Bit-rate divisor; rate = clk / (16*(div+1)) |
| nine_bit | input | 1 | 1 selects frames with a ninth data bit |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| wr_bit8 | input | 1 | Ninth bit to transmit |
| rd_en | input | 1 | Read strobe; acknowledges the received character |
| rd_data | output | 8 | Receive holding register |
| rd_bit8 | output | 1 | Ninth received bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_done | output | 1 | Unread character available |
| tx_done | output | 1 | Transmitter finished with nothing queued |
| tx_empty | output | 1 | Transmit holding register may be written |
| frame_err | output | 1 | Held character had a 0 stop bit |
| overrun | output | 1 | A character was lost to an unread one |

## Verification
The hardest states to reach from the ports are a start bit that fails its vote and an overrun. A failed start bit needs a low pulse short enough to be caught by only one sub-bit tick. The bench drives the receive line directly with a pulse one tick period long, then checks that no character appears and that the next real frame still arrives intact. For an overrun, two loopback frames are sent without a read. The bench then checks that the first byte is still held, and that a later, read character clears the flag. A stop bit of 0 is also driven by hand, since loopback never produces one.

// File: rtl/uart_x16.sv
module uart_x16 #(
  parameter int DIVW = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  input  logic            nine_bit,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            wr_bit8,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic            rd_bit8,
  input  logic            rxd,
  output logic            txd,
  output logic            rx_done,
  output logic            tx_done,
  output logic            tx_empty,
  output logic            frame_err,
  output logic            overrun
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);

  logic [DIVW-1:0] bcnt;
  logic            tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          bcnt <= '0;
    else if (bcnt == '0) bcnt <= div;
    else                 bcnt <= bcnt - DIVW'(1);

  assign tick = (bcnt == '0);

  // transmitter
  logic [DW-1:0] tbuf;
  logic          tb8, tfull, tbusy;
  logic [FW-1:0] tsr;
  logic [3:0]    tph;
  logic [CW-1:0] tleft;
  logic          tload;

  assign tload = tick && tfull && !tbusy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tbuf <= '0; tb8 <= 1'b0; tfull <= 1'b0; tbusy <= 1'b0;
      tsr <= '1; tph <= '0; tleft <= '0; tx_done <= 1'b0;
    end else begin
      if (tload) begin
        tbusy <= 1'b1;
        tfull <= 1'b0;
        tph   <= '0;
        tleft <= nine_bit ? CW'(FW) : CW'(FW - 1);
        tsr   <= {1'b1, nine_bit ? tb8 : 1'b1, tbuf, 1'b0};
      end else if (tbusy && tick) begin
        tph <= tph + 4'd1;
        if (tph == 4'd15) begin
          tsr   <= {1'b1, tsr[FW-1:1]};
          tleft <= tleft - CW'(1);
          if (tleft == CW'(1)) begin
            tbusy <= 1'b0;
            if (!tfull) tx_done <= 1'b1;
          end
        end
      end
      if (wr_en) begin
        tbuf    <= wr_data;
        tb8     <= wr_bit8;
        tfull   <= 1'b1;
        tx_done <= 1'b0;
      end
    end

  assign txd      = tbusy ? tsr[0] : 1'b1;
  assign tx_empty = !tfull;

  // receiver
  logic [1:0]    rsync;
  logic          rs, ract, maj, pend;
  logic [3:0]    rph;
  logic [CW-1:0] ridx, rlast;
  logic [1:0]    vote;
  logic [DW:0]   rsr;
  logic [DW-1:0] rdat;
  logic          rb8;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b11;
    else        rsync <= {rsync[0], rxd};

  assign rs    = rsync[1];
  assign maj   = (vote[0] & vote[1]) | (vote[0] & rs) | (vote[1] & rs);
  assign rlast = nine_bit ? CW'(DW + 2) : CW'(DW + 1);
  assign pend  = rx_done && !rd_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ract <= 1'b0; rph <= '0; ridx <= '0; vote <= '0; rsr <= '0;
      rdat <= '0; rb8 <= 1'b0; rx_done <= 1'b0; frame_err <= 1'b0; overrun <= 1'b0;
    end else begin
      if (rd_en) rx_done <= 1'b0;
      if (tick) begin
        if (!ract) begin
          if (!rs) begin
            ract <= 1'b1;
            rph  <= 4'd1;
            ridx <= '0;
          end
        end else begin
          rph <= rph + 4'd1;
          if (rph == 4'd7) vote[0] <= rs;
          if (rph == 4'd8) vote[1] <= rs;
          if (rph == 4'd9) begin
            ridx <= ridx + CW'(1);
            if (ridx == '0) begin
              if (maj) ract <= 1'b0;
            end else if (ridx == rlast) begin
              ract <= 1'b0;
              if (pend) overrun <= 1'b1;
              else begin
                rdat      <= rsr[DW-1:0];
                rb8       <= nine_bit ? rsr[DW] : 1'b0;
                rx_done   <= 1'b1;
                overrun   <= 1'b0;
                frame_err <= !maj;
              end
            end else begin
              rsr[ridx - CW'(1)] <= maj;
            end
          end
        end
      end
    end

  assign rd_data = rdat;
  assign rd_bit8 = rb8;

  assert_empty_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> !txd);
  assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (txd && tx_empty));
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (rx_done && $stable(rd_data)));
  assert_ferr_with_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> rx_done);
endmodule

// File: tb/uart_x16_tb.sv
module uart_x16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd0;
  logic       nine_bit = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_bit8 = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit8;
  logic       txd, rx_done, tx_done, tx_empty, frame_err, overrun;
  logic       loop_en = 1'b1;
  logic       rx_drv = 1'b1;
  logic       rxd;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  uart_x16 u_dut (
    .clk(clk), .rst_n(rst_n), .div(div), .nine_bit(nine_bit),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bit8(wr_bit8), .rd_en(rd_en),
    .rd_data(rd_data), .rd_bit8(rd_bit8), .rxd(rxd), .txd(txd),
    .rx_done(rx_done), .tx_done(tx_done), .tx_empty(tx_empty),
    .frame_err(frame_err), .overrun(overrun)
  );

  // {nine_bit, div, ninth bit + data}; all data odd so the start bit length is visible
  localparam logic [17:0] VEC [0:5] = '{
    {1'b0, 8'd0, 9'h055}, {1'b0, 8'd1, 9'h0A5}, {1'b1, 8'd2, 9'h13D},
    {1'b1, 8'd0, 9'h0FF}, {1'b0, 8'd3, 9'h001}, {1'b1, 8'd1, 9'h1C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d[7:0]; wr_bit8 = d[8];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_rx(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (rx_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_txdone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (tx_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_raw(input logic [11:0] bits, input int n, input int p);
    for (int i = 0; i < n; i++) begin
      rx_drv = bits[i];
      repeat (p) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    int p, len, nb;
    logic [11:0] got, exp;
    logic [8:0] d;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 txd", txd, 1);
    chk("R10 tx_empty", tx_empty, 1);
    chk("R10 tx_done", tx_done, 0);
    chk("R10 rx_done", rx_done, 0);
    chk("R10 frame_err", frame_err, 0);
    chk("R10 overrun", overrun, 0);

    for (int v = 0; v < 6; v++) begin
      nine_bit = VEC[v][17];
      div      = VEC[v][16:9];
      d        = VEC[v][8:0];
      loop_en  = 1'b1;
      p = 16 * (int'(div) + 1);
      nb = nine_bit ? 11 : 10;
      wr(d);
      chk("R3 empty low after write", tx_empty, 0);
      for (int i = 0; i < 100 && txd; i++) @(negedge clk);
      chk("R3 empty at start bit", tx_empty, 1);
      len = 0;
      while (txd == 1'b0 && len < 5000) begin len++; @(negedge clk); end
      chk("R1 start bit length", len, p);
      repeat (p / 2) @(negedge clk);
      got = '0;
      for (int b = 1; b < nb; b++) begin
        got[b] = txd;
        if (b < nb - 1) repeat (p) @(negedge clk);
      end
      exp = '0;
      exp[8:1] = d[7:0];
      if (nine_bit) begin exp[9] = d[8]; exp[10] = 1'b1; end
      else exp[9] = 1'b1;
      chk("R2 frame bits", got, exp);
      wait_rx(ok);
      chk("R5 rx_done", ok, 1);
      chk("R5 rd_data", rd_data, d[7:0]);
      chk("R5 rd_bit8", rd_bit8, nine_bit ? d[8] : 1'b0);
      chk("R7 frame_err clear", frame_err, 0);
      rd();
      chk("R9 rx_done cleared", rx_done, 0);
      wait_txdone(ok);
      chk("R4 tx_done", ok, 1);
      chk("R4 tx_empty idle", tx_empty, 1);
    end

    // back-to-back: no tx_done between queued frames
    nine_bit = 1'b0; div = 8'd1; loop_en = 1'b1;
    wr(9'h0B7);
    for (int i = 0; i < 100 && !tx_empty; i++) @(negedge clk);
    wr(9'h049);
    chk("R3 second byte queued", tx_empty, 0);
    chk("R4 done cleared by write", tx_done, 0);
    wait_rx(ok);
    chk("R5 first of pair", rd_data, 8'hB7);
    rd();
    ok = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 5000; i++) begin
        if (tx_done) seen = 1'b1;
        if (rx_done) begin ok = 1'b1; break; end
        @(negedge clk);
      end
      chk("R4 no done between frames", seen, 0);
    end
    chk("R5 second of pair", rd_data, 8'h49);
    rd();
    wait_txdone(ok);
    chk("R4 done after pair", ok, 1);

    // overrun
    div = 8'd0;
    wr(9'h0A1);
    wait_rx(ok);
    wr(9'h05E);
    wait_txdone(ok);
    repeat (4) @(negedge clk);
    chk("R8 overrun set", overrun, 1);
    chk("R8 first kept", rd_data, 8'hA1);
    chk("R8 rx_done held", rx_done, 1);
    rd();
    chk("R9 cleared after read", rx_done, 0);
    wr(9'h033);
    wait_rx(ok);
    chk("R8 next char", rd_data, 8'h33);
    chk("R8 overrun cleared", overrun, 0);
    rd();
    wait_txdone(ok);

    // bad stop bit driven by hand
    loop_en = 1'b0; rx_drv = 1'b1; div = 8'd1; nine_bit = 1'b0;
    repeat (40) @(negedge clk);
    send_raw({2'b00, 1'b0, 8'h96, 1'b0}, 10, 32);
    repeat (64) @(negedge clk);
    wait_rx(ok);
    chk("R7 char with bad stop", rd_data, 8'h96);
    chk("R7 frame_err set", frame_err, 1);
    rd();
    send_raw({2'b00, 1'b1, 8'h3C, 1'b0}, 10, 32);
    wait_rx(ok);
    chk("R7 frame_err clear on good stop", frame_err, 0);
    chk("R5 hand driven data", rd_data, 8'h3C);
    wr(9'h0C3);
    repeat (10) @(negedge clk);
    chk("R11 rd_data after write", rd_data, 8'h3C);
    wait_txdone(ok);
    rd();

    // false start: one tick-long low pulse
    div = 8'd3;
    repeat (80) @(negedge clk);
    rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (3 * 64) @(negedge clk);
    chk("R6 no char from glitch", rx_done, 0);
    send_raw({2'b00, 1'b1, 8'h5A, 1'b0}, 10, 64);
    wait_rx(ok);
    chk("R6 frame after glitch", ok, 1);
    chk("R6 data after glitch", rd_data, 8'h5A);
    rd();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule